// File: doc/BRIEF.md
# Threshold-Interrupt FIFO Pair for a Serial Peripheral Port

This block sits between the register file of an SPI controller and its shift engine. It keeps two byte-wide queues: a transmit queue filled by software and drained by the shift engine, and a receive queue filled by the shift engine and drained by software. Both queues have the same compile-time depth, 64 or 128 entries.

Software programs one 8-bit fill threshold per direction through a FIFO control word. The block raises a receive-ready status bit when enough bytes are waiting to be read, and a transmit-refill status bit when the transmit queue has drained far enough to take more data. It also flags a receive overrun and records a transfer-complete pulse from the shift engine. Status bits are sticky and cleared by writing ones, so software can refill or drain a queue before acknowledging. A single interrupt line is raised when any pending bit is also enabled.

Top module: `sfifo_irq`

## Requirements
- R1: Bytes written on the register side (`tx_wr`) leave at the engine side in write order; `eng_tx_data` shows the oldest byte and `eng_tx_avail` is high while the transmit queue holds data. A write into a full transmit queue is dropped.
- R2: Bytes pushed by the shift engine (`eng_rx_push`) are returned in push order on `rx_rdata`, which shows the oldest byte; `rx_rd` removes it.
- R3: `DEPTH` may be 64 or 128. The status word `fsta` carries the receive fill count in bits 7:0 and the transmit fill count in bits 23:16, and a queue holds at most `DEPTH` bytes.
- R4: In the control word, bits 7:0 hold the receive threshold and bits 23:16 the transmit threshold; a write stores both. Writing 1 to bit 15 empties the receive queue and writing 1 to bit 31 empties the transmit queue, so the count reads 0 after that edge; bits 15 and 31 read back as 0.
- R5: Status bit 0 (receive ready) is set one cycle after the receive count is at or above the receive threshold.
- R6: Status bit 4 (transmit refill) is set one cycle after the transmit count is at or below the transmit threshold.
- R7: Status bit 8 (receive overrun) is set on the edge after a push into a full receive queue; the pushed byte is dropped and the stored bytes are unchanged.
- R8: Status bit 12 (transfer complete) is set on the edge after a `xfer_done` pulse.
- R9: Writing `ista_wdata` with `ista_wr` clears each status bit written with 1 and leaves bits written with 0; all ones clears every bit. A threshold condition that still holds sets its bit again on the following edge.
- R10: `irq` is high exactly when some status bit is set and its enable bit (same position in `ien_q`) is set; only bits 0, 4, 8 and 12 of the enable word are stored, the rest read 0.
- R11: During reset both counts and all status and enable bits are 0, `irq` is low, and both thresholds read three quarters of `DEPTH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_wr | input | 1 | Register-side write into the transmit queue |
| tx_wdata | input | 8 | Byte to enqueue for transmission |
| rx_rd | input | 1 | Register-side removal of the oldest received byte |
| rx_rdata | output | 8 | Oldest received byte |
| eng_tx_pop | input | 1 | Shift engine takes the oldest transmit byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_avail | output | 1 | Transmit queue not empty |
| eng_rx_push | input | 1 | Shift engine delivers a received byte |
| eng_rx_data | input | 8 | Received byte from the shift engine |
| xfer_done | input | 1 | One-cycle pulse at the end of a transfer |
| fctl_wr | input | 1 | Write strobe for the FIFO control word |
| fctl_wdata | input | 32 | FIFO control word: thresholds and queue flush bits |
| fctl_q | output | 32 | Read-back of the stored thresholds |
| fsta | output | 32 | Fill counts of both queues |
| ien_wr | input | 1 | Write strobe for the interrupt enable word |
| ien_wdata | input | 32 | New interrupt enable word |
| ien_q | output | 32 | Stored interrupt enables |
| ista_wr | input | 1 | Write-one-to-clear strobe for the status word |
| ista_wdata | input | 32 | Clear mask for the status word |
| ista | output | 32 | Pending status bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two copies side by side from the same stimulus, one with `DEPTH` 64 and one with `DEPTH` 128. The shallow copy makes a full queue, a dropped overrun byte and a threshold equal to the full depth reachable in a few dozen pushes, while the deep copy, fed the same 70 bytes, shows that the same traffic is absorbed without overrun and that a count above 64 is reported in the 8-bit field. Their different reset thresholds (48 and 96) are checked against each other, and a threshold table walks both copies through levels below, at and above the fill.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

   localparam int unsigned BYTE_W = 8;
   localparam int unsigned WORD_W = 32;
   localparam int unsigned LVL_W  = 8;

   // status sources, index order is also the enable/status bit order
   localparam int unsigned NSRC     = 4;
   localparam int unsigned S_RXRDY  = 0;
   localparam int unsigned S_TXREQ  = 1;
   localparam int unsigned S_RXOVF  = 2;
   localparam int unsigned S_DONE   = 3;
   localparam int unsigned SRC_POS   [NSRC] = '{0, 4, 8, 12};
   localparam bit          SRC_LEVEL [NSRC] = '{1'b1, 1'b1, 1'b0, 1'b0};

   // control and status word fields
   localparam int unsigned RX_LVL_LSB   = 0;
   localparam int unsigned TX_LVL_LSB   = 16;
   localparam int unsigned RX_FLUSH_BIT = 15;
   localparam int unsigned TX_FLUSH_BIT = 31;
   localparam int unsigned RX_CNT_LSB   = 0;
   localparam int unsigned TX_CNT_LSB   = 16;

   function automatic logic [WORD_W-1:0] src_mask();
      logic [WORD_W-1:0] m;
      m = '0;
      for (int i = 0; i < NSRC; i++) m[SRC_POS[i]] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/sfifo_mem.sv
module sfifo_mem #(
   parameter  int unsigned DEPTH = 128,
   parameter  int unsigned DW    = 8,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] cnt,
   output logic          full,
   output logic          empty,
   output logic          ovf
);

   if (DEPTH != 64 && DEPTH != 128) begin : g_bad_depth
      $error("sfifo_mem: DEPTH must be 64 or 128");
   end
   if (DW < 1) begin : g_bad_width
      $error("sfifo_mem: DW must be positive");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign ovf     = push & full & ~flush;
   assign rdata   = mem[rptr];
   assign cnt     = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt_q <= '0;
      end else if (flush) begin
         wptr  <= '0;
         rptr  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wptr <= wptr + AW'(1);
         if (do_pop)  rptr <= rptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wptr] <= wdata;
   end

   // R3: never more than DEPTH entries
   a_r3_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));

   // R4: flush empties the queue on the next edge
   a_r4_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (cnt == '0));

   // R7 / R1: a push into a full queue is dropped
   a_r7_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> full);

   // R2: removing from an empty queue changes nothing
   a_r2_pop_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push && !flush) |=> empty);

endmodule

// File: rtl/sfifo_cfg.sv
module sfifo_cfg
   import sfifo_pkg::*;
#(
   parameter  int unsigned DEPTH   = 128,
   localparam logic [LVL_W-1:0] LVL_RST = LVL_W'(DEPTH / 4 * 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [WORD_W-1:0] wdata,
   output logic [LVL_W-1:0]  rx_lvl,
   output logic [LVL_W-1:0]  tx_lvl,
   output logic              flush_rx,
   output logic              flush_tx,
   output logic [WORD_W-1:0] cfg_q
);

   if (DEPTH / 4 * 3 >= (1 << LVL_W)) begin : g_bad_lvl
      $error("sfifo_cfg: reset threshold does not fit the level field");
   end

   logic unused_cfg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_lvl <= LVL_RST;
         tx_lvl <= LVL_RST;
      end else if (wr) begin
         rx_lvl <= wdata[RX_LVL_LSB +: LVL_W];
         tx_lvl <= wdata[TX_LVL_LSB +: LVL_W];
      end
   end

   // flush strobes act on the write cycle only, nothing is stored
   assign flush_rx = wr & wdata[RX_FLUSH_BIT];
   assign flush_tx = wr & wdata[TX_FLUSH_BIT];

   always_comb begin
      cfg_q = '0;
      cfg_q[RX_LVL_LSB +: LVL_W] = rx_lvl;
      cfg_q[TX_LVL_LSB +: LVL_W] = tx_lvl;
   end

   assign unused_cfg = ^{wdata[30:24], wdata[14:8]};

endmodule

// File: rtl/sfifo_irq_ctrl.sv
module sfifo_irq_ctrl
   import sfifo_pkg::*;
#(
   parameter int unsigned CW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CW-1:0]     rx_cnt,
   input  logic [CW-1:0]     tx_cnt,
   input  logic [LVL_W-1:0]  rx_lvl,
   input  logic [LVL_W-1:0]  tx_lvl,
   input  logic              ovf_evt,
   input  logic              done_evt,
   input  logic              ien_wr,
   input  logic [WORD_W-1:0] ien_wdata,
   input  logic              clr_wr,
   input  logic [WORD_W-1:0] clr_wdata,
   output logic [WORD_W-1:0] sts_word,
   output logic [WORD_W-1:0] ien_word,
   output logic              irq
);

   if (CW > 16) begin : g_bad_cw
      $error("sfifo_irq_ctrl: count width out of range");
   end

   localparam logic [WORD_W-1:0] MASK = src_mask();

   logic [NSRC-1:0] cond, sts, ien;
   logic            unused_ien;

   assign cond[S_RXRDY] = (int'(rx_cnt) >= int'(rx_lvl));
   assign cond[S_TXREQ] = (int'(tx_cnt) <= int'(tx_lvl));
   assign cond[S_RXOVF] = ovf_evt;
   assign cond[S_DONE]  = done_evt;

   for (genvar g = 0; g < NSRC; g++) begin : g_src
      localparam int unsigned P = SRC_POS[g];
      logic clr;
      assign clr = clr_wr & clr_wdata[P];

      if (SRC_LEVEL[g]) begin : g_level
         // a clear wins in its own cycle; a live condition re-sets next cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sts[g] <= 1'b0;
            else if (clr) sts[g] <= 1'b0;
            else          sts[g] <= sts[g] | cond[g];
         end
      end else begin : g_event
         // an event arriving with its own clear is kept
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sts[g] <= 1'b0;
            else        sts[g] <= (sts[g] & ~clr) | cond[g];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      ien[g] <= 1'b0;
         else if (ien_wr) ien[g] <= ien_wdata[P];
      end
   end

   always_comb begin
      sts_word = '0;
      ien_word = '0;
      for (int i = 0; i < NSRC; i++) begin
         sts_word[SRC_POS[i]] = sts[i];
         ien_word[SRC_POS[i]] = ien[i];
      end
   end

   assign irq        = |(sts & ien);
   assign unused_ien = ^(ien_wdata & ~MASK);

   // R9: a written one clears a level bit on that edge
   a_r9_clear_level: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && clr_wdata[SRC_POS[S_RXRDY]]) |=> !sts_word[SRC_POS[S_RXRDY]]);

   // R9: a written zero leaves a pending bit alone
   a_r9_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_word[SRC_POS[S_DONE]] && !(clr_wr && clr_wdata[SRC_POS[S_DONE]]))
      |=> sts_word[SRC_POS[S_DONE]]);

   // R7: overrun is flagged on the next edge
   a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> sts_word[SRC_POS[S_RXOVF]]);

   // R8: completion pulse is captured
   a_r8_done_flag: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt |=> sts_word[SRC_POS[S_DONE]]);

   // R5: reaching the receive threshold raises ready unless cleared
   a_r5_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(rx_cnt) >= int'(rx_lvl) && !(clr_wr && clr_wdata[SRC_POS[S_RXRDY]]))
      |=> sts_word[SRC_POS[S_RXRDY]]);

   // R10: no enable, no interrupt
   a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_wr && ien_wdata == '0) |=> !irq);

endmodule

// File: rtl/sfifo_irq.sv
module sfifo_irq
   import sfifo_pkg::*;
#(
   parameter  int unsigned DEPTH = 128,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_wr,
   input  logic [7:0]        tx_wdata,
   input  logic              rx_rd,
   output logic [7:0]        rx_rdata,
   input  logic              eng_tx_pop,
   output logic [7:0]        eng_tx_data,
   output logic              eng_tx_avail,
   input  logic              eng_rx_push,
   input  logic [7:0]        eng_rx_data,
   input  logic              xfer_done,
   input  logic              fctl_wr,
   input  logic [31:0]       fctl_wdata,
   output logic [31:0]       fctl_q,
   output logic [31:0]       fsta,
   input  logic              ien_wr,
   input  logic [31:0]       ien_wdata,
   output logic [31:0]       ien_q,
   input  logic              ista_wr,
   input  logic [31:0]       ista_wdata,
   output logic [31:0]       ista,
   output logic              irq
);

   if (CW > LVL_W) begin : g_bad_cnt_field
      $error("sfifo_irq: fill count does not fit its status field");
   end

   logic [LVL_W-1:0] rx_lvl, tx_lvl;
   logic             flush_rx, flush_tx;
   logic [CW-1:0]    rx_cnt, tx_cnt;
   logic             rx_full, rx_empty, rx_ovf;
   logic             tx_full, tx_empty, tx_ovf_unused;

   sfifo_cfg #(.DEPTH(DEPTH)) cfg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (fctl_wr),
      .wdata    (fctl_wdata),
      .rx_lvl   (rx_lvl),
      .tx_lvl   (tx_lvl),
      .flush_rx (flush_rx),
      .flush_tx (flush_tx),
      .cfg_q    (fctl_q)
   );

   sfifo_mem #(.DEPTH(DEPTH), .DW(BYTE_W)) txq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_tx),
      .push  (tx_wr),
      .wdata (tx_wdata),
      .pop   (eng_tx_pop),
      .rdata (eng_tx_data),
      .cnt   (tx_cnt),
      .full  (tx_full),
      .empty (tx_empty),
      .ovf   (tx_ovf_unused)
   );

   sfifo_mem #(.DEPTH(DEPTH), .DW(BYTE_W)) rxq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_rx),
      .push  (eng_rx_push),
      .wdata (eng_rx_data),
      .pop   (rx_rd),
      .rdata (rx_rdata),
      .cnt   (rx_cnt),
      .full  (rx_full),
      .empty (rx_empty),
      .ovf   (rx_ovf)
   );

   sfifo_irq_ctrl #(.CW(CW)) irq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_cnt    (rx_cnt),
      .tx_cnt    (tx_cnt),
      .rx_lvl    (rx_lvl),
      .tx_lvl    (tx_lvl),
      .ovf_evt   (rx_ovf),
      .done_evt  (xfer_done),
      .ien_wr    (ien_wr),
      .ien_wdata (ien_wdata),
      .clr_wr    (ista_wr),
      .clr_wdata (ista_wdata),
      .sts_word  (ista),
      .ien_word  (ien_q),
      .irq       (irq)
   );

   assign eng_tx_avail = ~tx_empty;

   always_comb begin
      fsta = '0;
      fsta[RX_CNT_LSB +: LVL_W] = LVL_W'(rx_cnt);
      fsta[TX_CNT_LSB +: LVL_W] = LVL_W'(tx_cnt);
   end

   // R1: a write into a full transmit queue keeps it full and unchanged in size
   a_r1_tx_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && tx_full && !eng_tx_pop && !flush_tx) |=> (tx_cnt == CW'(DEPTH)));

   // R2: read of an empty receive queue is harmless
   a_r2_rx_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && rx_empty && !eng_rx_push && !flush_rx) |=> (fsta[RX_CNT_LSB +: LVL_W] == '0));

endmodule

// File: tb/sfifo_irq_tb.sv
module sfifo_irq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_wr = 1'b0, rx_rd = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
   logic        xfer_done = 1'b0, fctl_wr = 1'b0, ien_wr = 1'b0, ista_wr = 1'b0;
   logic [7:0]  tx_wdata = '0, eng_rx_data = '0;
   logic [31:0] fctl_wdata = '0, ien_wdata = '0, ista_wdata = '0;

   logic [7:0]  rx_rdata, eng_tx_data, rx_rdata_b, eng_tx_data_b;
   logic        eng_tx_avail, irq, eng_tx_avail_b, irq_b;
   logic [31:0] fctl_q, fsta, ien_q, ista, fctl_q_b, fsta_b, ien_q_b, ista_b;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #10 clk = ~clk;

   sfifo_irq #(.DEPTH(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .rx_rd(rx_rd), .rx_rdata(rx_rdata), .eng_tx_pop(eng_tx_pop),
      .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .xfer_done(xfer_done),
      .fctl_wr(fctl_wr), .fctl_wdata(fctl_wdata), .fctl_q(fctl_q), .fsta(fsta),
      .ien_wr(ien_wr), .ien_wdata(ien_wdata), .ien_q(ien_q),
      .ista_wr(ista_wr), .ista_wdata(ista_wdata), .ista(ista), .irq(irq));

   sfifo_irq #(.DEPTH(128)) dut128_i (
      .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_wdata(tx_wdata),
      .rx_rd(rx_rd), .rx_rdata(rx_rdata_b), .eng_tx_pop(eng_tx_pop),
      .eng_tx_data(eng_tx_data_b), .eng_tx_avail(eng_tx_avail_b),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .xfer_done(xfer_done),
      .fctl_wr(fctl_wr), .fctl_wdata(fctl_wdata), .fctl_q(fctl_q_b), .fsta(fsta_b),
      .ien_wr(ien_wr), .ien_wdata(ien_wdata), .ien_q(ien_q_b),
      .ista_wr(ista_wr), .ista_wdata(ista_wdata), .ista(ista_b), .irq(irq_b));

   // receive threshold table: {level, bytes pushed, expected ready bit}
   localparam int NTBL = 7;
   localparam logic [16:0] RDY_TBL [NTBL] = '{
      {8'd48,  8'd47, 1'b0},
      {8'd48,  8'd48, 1'b1},
      {8'd0,   8'd0,  1'b1},
      {8'd64,  8'd63, 1'b0},
      {8'd64,  8'd64, 1'b1},
      {8'd5,   8'd30, 1'b1},
      {8'd200, 8'd64, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic push_rx(input logic [7:0] b);
      eng_rx_push = 1'b1; eng_rx_data = b; step(); eng_rx_push = 1'b0;
   endtask
   task automatic wr_tx(input logic [7:0] b);
      tx_wr = 1'b1; tx_wdata = b; step(); tx_wr = 1'b0;
   endtask
   task automatic pop_tx();
      eng_tx_pop = 1'b1; step(); eng_tx_pop = 1'b0;
   endtask
   task automatic rd_rx();
      rx_rd = 1'b1; step(); rx_rd = 1'b0;
   endtask
   task automatic wr_fctl(input logic [31:0] v);
      fctl_wr = 1'b1; fctl_wdata = v; step(); fctl_wr = 1'b0;
   endtask
   task automatic wr_ien(input logic [31:0] v);
      ien_wr = 1'b1; ien_wdata = v; step(); ien_wr = 1'b0;
   endtask
   task automatic w1c(input logic [31:0] v);
      ista_wr = 1'b1; ista_wdata = v; step(); ista_wr = 1'b0;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      if (!ended) begin
         bad++;
         total++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int errs;
      // ---- R11: reset state ----
      repeat (3) step();
      chk("R11 ista64", ista, 32'h0);
      chk("R11 fsta64", fsta, 32'h0);
      chk("R11 irq64", {31'd0, irq}, 32'h0);
      chk("R11 ien64", ien_q, 32'h0);
      chk("R11 thresholds64", fctl_q, 32'h0030_0030);
      chk("R11 thresholds128", fctl_q_b, 32'h0060_0060);
      chk("R11 avail", {31'd0, eng_tx_avail}, 32'h0);
      rst_n = 1'b1;
      step(); step();
      // R6: empty transmit queue is at or below its threshold
      chk("R6 refill after reset", ista & 32'h11, 32'h10);

      // ---- R5 / R3: threshold table ----
      for (int k = 0; k < NTBL; k++) begin
         logic [16:0] ent;
         ent = RDY_TBL[k];
         wr_fctl((32'd48 << 16) | 32'h8000 | {24'd0, ent[16:9]});
         w1c(32'h1);
         for (int i = 0; i < int'(ent[8:1]); i++) push_rx(8'(i));
         step();
         chk($sformatf("R5 ready64 row %0d", k), {31'd0, ista[0]}, {31'd0, ent[0]});
         chk($sformatf("R5 ready128 row %0d", k), {31'd0, ista_b[0]}, {31'd0, ent[0]});
         chk($sformatf("R3 rx count row %0d", k), fsta & 32'hFF, {24'd0, ent[8:1]});
      end

      // ---- R4: flush and threshold read-back ----
      wr_fctl(32'h0030_8030);
      chk("R4 rx flush64", fsta & 32'hFF, 32'h0);
      chk("R4 rx flush128", fsta_b & 32'hFF, 32'h0);
      chk("R4 readback", fctl_q, 32'h0030_0030);

      // ---- R2: receive order ----
      push_rx(8'hA5); push_rx(8'h3C); push_rx(8'h7E); push_rx(8'h01);
      errs = 0;
      if (rx_rdata !== 8'hA5) errs++; rd_rx();
      if (rx_rdata !== 8'h3C) errs++; rd_rx();
      if (rx_rdata !== 8'h7E) errs++; rd_rx();
      if (rx_rdata !== 8'h01) errs++; rd_rx();
      chk("R2 rx order mismatches", errs, 0);
      chk("R2 rx empty", fsta & 32'hFF, 32'h0);

      // ---- R1 / R6: transmit order and refill threshold ----
      wr_tx(8'h11); wr_tx(8'h22); wr_tx(8'h33);
      chk("R3 tx count field", fsta & 32'h00FF_0000, 32'h0003_0000);
      chk("R1 avail", {31'd0, eng_tx_avail}, 32'h1);
      wr_fctl(32'h0002_0030);
      w1c(32'h10);
      step();
      chk("R6 above threshold stays clear", {31'd0, ista[4]}, 32'h0);
      chk("R1 head 1", {24'd0, eng_tx_data}, 32'h11);
      pop_tx();
      step();
      chk("R6 refill at threshold", {31'd0, ista[4]}, 32'h1);
      chk("R1 head 2", {24'd0, eng_tx_data}, 32'h22);
      pop_tx();
      chk("R1 head 3", {24'd0, eng_tx_data}, 32'h33);
      pop_tx();
      chk("R1 drained", {31'd0, eng_tx_avail}, 32'h0);

      // ---- R7: overrun on the 64-deep copy only ----
      wr_fctl(32'h0030_8030);
      w1c(32'hFFFF_FFFF);
      for (int i = 0; i < 70; i++) push_rx(8'(i));
      step();
      chk("R7 count64 capped", fsta & 32'hFF, 32'd64);
      chk("R7 overrun64", {31'd0, ista[8]}, 32'h1);
      chk("R3 count128", fsta_b & 32'hFF, 32'd70);
      chk("R7 no overrun128", {31'd0, ista_b[8]}, 32'h0);

      // ---- R9: write-one-to-clear ----
      w1c(32'h0000_0100);
      chk("R9 selective clear", ista & 32'h101, 32'h001);
      w1c(32'hFFFF_FFFF);
      chk("R9 clear all", ista & 32'h1111, 32'h0);
      step();
      chk("R9 level re-sets", ista & 32'h101, 32'h001);

      errs = 0;
      for (int i = 0; i < 64; i++) begin
         if (rx_rdata !== 8'(i)) errs++;
         rd_rx();
      end
      chk("R7 stored bytes intact", errs, 0);

      // ---- R8 / R10: completion and interrupt gating ----
      xfer_done = 1'b1; step(); xfer_done = 1'b0;
      chk("R8 done", {31'd0, ista[12]}, 32'h1);
      wr_ien(32'hFFFF_FFFF);
      chk("R10 enable readback", ien_q, 32'h0000_1111);
      chk("R10 irq enabled", {31'd0, irq}, 32'h1);
      wr_ien(32'h0);
      chk("R10 irq disabled", {31'd0, irq}, 32'h0);
      wr_ien(32'h1000);
      chk("R10 irq by done", {31'd0, irq}, 32'h1);
      w1c(32'h1000);
      chk("R9 done cleared", {31'd0, ista[12]}, 32'h0);
      chk("R10 irq dropped", {31'd0, irq}, 32'h0);

      // ---- R1 / R4: full transmit queue and its flush ----
      for (int i = 0; i < 70; i++) wr_tx(8'(i));
      chk("R1 tx capped64", fsta & 32'h00FF_0000, 32'h0040_0000);
      chk("R3 tx count128", fsta_b & 32'h00FF_0000, 32'h0046_0000);
      chk("R1 tx head kept", {24'd0, eng_tx_data}, 32'h0);
      wr_fctl(32'h8030_0030);
      chk("R4 tx flush64", fsta & 32'h00FF_0000, 32'h0);
      chk("R4 tx flush128", fsta_b & 32'h00FF_0000, 32'h0);
      chk("R4 flush bits read zero", fctl_q & 32'h8000_8000, 32'h0);

      summary();
      $finish;
   end

endmodule